// File: doc/BRIEF.md
# Thread Block Dispatcher with Admission Control

This block takes one kernel launch at a time and hands its thread blocks, in increasing block ID order, to a row of multiprocessor slots. A launch gives the number of blocks, the threads per block and the registers each thread needs. Each block is placed whole on one multiprocessor, and only when that multiprocessor still has a free block slot, room for the block's threads and room in its register file for the block's register demand.

For every multiprocessor the dispatcher keeps a ledger of resident blocks, resident threads, allocated registers and resident warps. A completion pulse naming a multiprocessor returns one block's worth of resources. That release is applied before the admission check of the same clock edge, so a multiprocessor that was full can take the next block on the edge where the pulse is registered. Blocks are handed out one per clock to the lowest-indexed multiprocessor that can take them. A level output shows whether the launch is still in progress.

Top module: `blk_dispatch`

## Requirements
- R1: A block is assigned to a multiprocessor only if all three limits (R2, R3, R4) still hold after the block is added. If no multiprocessor qualifies, dispatch waits and the block is never split.
- R2: No multiprocessor ever holds more than MAX_BLOCKS_PER_MP (default 8) resident blocks. With 64-thread blocks each multiprocessor stops at 8 blocks and 512 threads.
- R3: The resident threads of a multiprocessor never exceed MAX_THREADS_PER_MP (default 768). With 256-thread blocks, a multiprocessor takes 3 blocks.
- R4: A block's register demand is its thread count rounded up to a multiple of 32, times the registers per thread. The sum of demands on a multiprocessor never exceeds REGS_PER_MP (default 8192). 100 threads at 16 registers gives 2048 per block, so 4 blocks fit. A demand of exactly 8192 is accepted.
- R5: A launch offered while idle is rejected if it has 0 threads per block, more than MAX_BLOCK_THREADS (default 512) threads per block, or a register demand above REGS_PER_MP. A rejected launch gives a one-cycle `launch_reject` pulse after the edge that samples it. It assigns nothing, and `launch_done` stays high.
- R6: An accepted launch of N blocks assigns IDs 0 to N-1 in increasing order, at most one per clock. The first assignment is registered one edge after the edge that captures the launch.
- R7: Each block goes to the lowest-indexed multiprocessor that can accept it under R1.
- R8: A completion pulse releases one block's threads, registers and warps on the named multiprocessor on the edge where the pulse is sampled. A block may be admitted to that multiprocessor on the same edge.
- R9: `launch_done` is 1 out of reset and while idle. It falls on the edge that captures an accepted launch. It rises on the edge that registers the completion of the last outstanding block, once all blocks have been assigned. No assignment is presented while it is high.
- R10: `mp_warps` slice i (WRP_W bits, at bit i*WRP_W) equals the sum of ceil(threads/32) over the blocks resident on multiprocessor i.
- R11: A launch offered while busy is ignored, and so is a launch with zero blocks. A completion pulse naming a multiprocessor with no resident block changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | One-cycle launch request |
| launch_blocks | input | BID_W | Number of blocks in the launch |
| launch_threads | input | TPB_W | Threads per block |
| launch_regs | input | RPT_W | Registers per thread |
| launch_reject | output | 1 | Pulse: offered launch cannot fit anywhere |
| done_valid | input | 1 | One-cycle block completion pulse |
| done_mp | input | MP_W | Multiprocessor whose block completed |
| assign_valid | output | 1 | Assignment strobe |
| assign_block_id | output | BID_W | ID of the assigned block |
| assign_mp | output | MP_W | Target multiprocessor index |
| launch_done | output | 1 | High when no launch work is pending |
| mp_warps | output | NUM_MP*WRP_W | Resident warp count per multiprocessor |

## Verification
On every cycle the assertions check the following. The per-multiprocessor block, thread and register ledgers stay within their limits. No grant is given to a multiprocessor whose admission check failed. Consecutive assignment strobes carry consecutive block IDs. No strobe is present while `launch_done` is high, and a reject pulse never appears while a launch is active. The bench scenarios are needed for the rest: the exact placement pattern under each limiting resource, a freed multiprocessor being refilled on the same edge, correct rejection at and just past the boundaries, and ignored requests leaving both the ledgers and the block stream untouched.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
   localparam int WARP_SIZE = 32;
   localparam int WARP_LG   = $clog2(WARP_SIZE);

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } disp_state_e;
endpackage

// File: rtl/blk_lowest_pick.sv
module blk_lowest_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o
);
   generate
      if (N == 1) begin : g_single
         assign gnt_o = req_i;
      end else begin : g_multi
         // isolate the lowest set bit
         assign gnt_o = req_i & (~req_i + N'(1));
      end
   endgenerate
endmodule

// File: rtl/blk_mp_ledger.sv
module blk_mp_ledger #(
   parameter int MAX_BLK = 8,
   parameter int MAX_THR = 768,
   parameter int MAX_REG = 8192,
   parameter int BC_W    = 4,
   parameter int THR_W   = 10,
   parameter int REG_W   = 14,
   parameter int WRP_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             release_i,
   input  logic             grant_i,
   input  logic [THR_W-1:0] thr_cost_i,
   input  logic [REG_W-1:0] reg_cost_i,
   input  logic [WRP_W-1:0] wrp_cost_i,
   output logic             fits_o,
   output logic             release_ok_o,
   output logic [WRP_W-1:0] warps_o
);
   localparam logic [BC_W-1:0]  LIM_BLK = BC_W'(MAX_BLK);
   localparam logic [THR_W:0]   LIM_THR = (THR_W+1)'(MAX_THR);
   localparam logic [REG_W:0]   LIM_REG = (REG_W+1)'(MAX_REG);

   logic [BC_W-1:0]  blk_q, blk_eff;
   logic [THR_W-1:0] thr_q, thr_eff;
   logic [REG_W-1:0] reg_q, reg_eff;
   logic [WRP_W-1:0] wrp_q, wrp_eff;
   logic             rel_ok;

   // a release is applied before this edge's admission check
   assign rel_ok  = release_i && (blk_q != '0);
   assign blk_eff = blk_q - (rel_ok ? BC_W'(1) : '0);
   assign thr_eff = thr_q - (rel_ok ? thr_cost_i : '0);
   assign reg_eff = reg_q - (rel_ok ? reg_cost_i : '0);
   assign wrp_eff = wrp_q - (rel_ok ? wrp_cost_i : '0);

   assign fits_o = (blk_eff < LIM_BLK)
                && (({1'b0, thr_eff} + {1'b0, thr_cost_i}) <= LIM_THR)
                && (({1'b0, reg_eff} + {1'b0, reg_cost_i}) <= LIM_REG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_q <= '0;
         thr_q <= '0;
         reg_q <= '0;
         wrp_q <= '0;
      end else begin
         blk_q <= blk_eff + (grant_i ? BC_W'(1) : '0);
         thr_q <= thr_eff + (grant_i ? thr_cost_i : '0);
         reg_q <= reg_eff + (grant_i ? reg_cost_i : '0);
         wrp_q <= wrp_eff + (grant_i ? wrp_cost_i : '0);
      end
   end

   assign release_ok_o = rel_ok;
   assign warps_o      = wrp_q;

   assert_grant_fits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> fits_o);
   assert_block_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q <= LIM_BLK);
   assert_thread_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, thr_q} <= LIM_THR);
   assert_reg_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, reg_q} <= LIM_REG);
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
   import blk_dispatch_pkg::*;
#(
   parameter int NUM_MP            = 4,
   parameter int MAX_BLOCKS_PER_MP = 8,
   parameter int MAX_THREADS_PER_MP = 768,
   parameter int REGS_PER_MP       = 8192,
   parameter int MAX_BLOCK_THREADS = 512,
   parameter int BID_W             = 16,
   parameter int RPT_W             = 8,
   parameter int MP_W   = (NUM_MP > 1) ? $clog2(NUM_MP) : 1,
   parameter int TPB_W  = $clog2(MAX_BLOCK_THREADS) + 1,
   parameter int WRP_W  = $clog2(MAX_THREADS_PER_MP / WARP_SIZE + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    launch_valid,
   input  logic [BID_W-1:0]        launch_blocks,
   input  logic [TPB_W-1:0]        launch_threads,
   input  logic [RPT_W-1:0]        launch_regs,
   output logic                    launch_reject,
   input  logic                    done_valid,
   input  logic [MP_W-1:0]         done_mp,
   output logic                    assign_valid,
   output logic [BID_W-1:0]        assign_block_id,
   output logic [MP_W-1:0]         assign_mp,
   output logic                    launch_done,
   output logic [NUM_MP*WRP_W-1:0] mp_warps
);
   localparam int BC_W  = $clog2(MAX_BLOCKS_PER_MP + 1);
   localparam int THR_W = $clog2(MAX_THREADS_PER_MP + 1);
   localparam int REG_W = $clog2(REGS_PER_MP + 1);
   localparam int DEM_W = TPB_W + 1 + RPT_W;
   localparam int CNT_W = BID_W + 1;
   localparam logic [DEM_W-1:0] LIM_DEM = DEM_W'(REGS_PER_MP);
   localparam logic [TPB_W-1:0] LIM_TPB = TPB_W'(MAX_BLOCK_THREADS);
   localparam logic [TPB_W:0]   PAD     = (TPB_W+1)'(WARP_SIZE - 1);

   generate
      if (MAX_BLOCK_THREADS > MAX_THREADS_PER_MP) begin : g_chk_thr
         $error("block thread limit exceeds multiprocessor capacity");
      end
      if (NUM_MP < 1 || MAX_BLOCKS_PER_MP < 1) begin : g_chk_cnt
         $error("need at least one multiprocessor and one block slot");
      end
      if (MAX_BLOCK_THREADS % WARP_SIZE != 0) begin : g_chk_warp
         $error("block thread limit must be a warp multiple");
      end
   endgenerate

   // ---------------- launch decode ----------------
   logic [TPB_W:0]   thr_round;
   logic [DEM_W-1:0] demand;
   logic             bad_launch;

   assign thr_round  = ({1'b0, launch_threads} + PAD) & ~PAD;
   assign demand     = DEM_W'(thr_round) * DEM_W'(launch_regs);
   assign bad_launch = (launch_threads == '0) || (launch_threads > LIM_TPB)
                    || (demand > LIM_DEM);

   // ---------------- launch state ----------------
   disp_state_e      state_q;
   logic [BID_W-1:0] cfg_blocks;
   logic [THR_W-1:0] cfg_thr;
   logic [REG_W-1:0] cfg_reg;
   logic [WRP_W-1:0] cfg_wrp;
   logic [CNT_W-1:0] next_id, out_cnt, next_id_nxt, out_nxt;
   logic             can_issue, any_gnt, any_rel, accept;

   logic [NUM_MP-1:0] fits, req, gnt, rel, rel_ok;

   assign can_issue = (state_q == ST_RUN) && (next_id < {1'b0, cfg_blocks});
   assign req       = fits & {NUM_MP{can_issue}};

   blk_lowest_pick #(.N(NUM_MP)) u_pick (
      .req_i (req),
      .gnt_o (gnt)
   );

   generate
      for (genvar m = 0; m < NUM_MP; m++) begin : g_mp
         assign rel[m] = done_valid && (done_mp == MP_W'(m));

         blk_mp_ledger #(
            .MAX_BLK (MAX_BLOCKS_PER_MP),
            .MAX_THR (MAX_THREADS_PER_MP),
            .MAX_REG (REGS_PER_MP),
            .BC_W    (BC_W),
            .THR_W   (THR_W),
            .REG_W   (REG_W),
            .WRP_W   (WRP_W)
         ) u_ledger (
            .clk          (clk),
            .rst_n        (rst_n),
            .release_i    (rel[m]),
            .grant_i      (gnt[m]),
            .thr_cost_i   (cfg_thr),
            .reg_cost_i   (cfg_reg),
            .wrp_cost_i   (cfg_wrp),
            .fits_o       (fits[m]),
            .release_ok_o (rel_ok[m]),
            .warps_o      (mp_warps[m*WRP_W +: WRP_W])
         );
      end
   endgenerate

   logic [MP_W-1:0] gnt_idx;
   always_comb begin
      gnt_idx = '0;
      for (int m = 0; m < NUM_MP; m++) begin
         if (gnt[m]) gnt_idx = MP_W'(m);
      end
   end

   assign any_gnt     = |gnt;
   assign any_rel     = |rel_ok;
   assign accept      = (state_q == ST_IDLE) && launch_valid && !bad_launch
                     && (launch_blocks != '0);
   assign next_id_nxt = next_id + (any_gnt ? CNT_W'(1) : '0);
   assign out_nxt     = out_cnt + (any_gnt ? CNT_W'(1) : '0)
                                - (any_rel ? CNT_W'(1) : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q         <= ST_IDLE;
         cfg_blocks      <= '0;
         cfg_thr         <= '0;
         cfg_reg         <= '0;
         cfg_wrp         <= '0;
         next_id         <= '0;
         out_cnt         <= '0;
         launch_reject   <= 1'b0;
         assign_valid    <= 1'b0;
         assign_block_id <= '0;
         assign_mp       <= '0;
      end else begin
         launch_reject   <= (state_q == ST_IDLE) && launch_valid && bad_launch;
         assign_valid    <= any_gnt;
         assign_block_id <= next_id[BID_W-1:0];
         assign_mp       <= gnt_idx;
         out_cnt         <= out_nxt;
         if (accept) begin
            state_q    <= ST_RUN;
            cfg_blocks <= launch_blocks;
            cfg_thr    <= THR_W'(launch_threads);
            cfg_reg    <= REG_W'(demand);
            cfg_wrp    <= WRP_W'(thr_round >> WARP_LG);
            next_id    <= '0;
         end else if (state_q == ST_RUN) begin
            next_id <= next_id_nxt;
            if (next_id_nxt == {1'b0, cfg_blocks} && out_nxt == '0) begin
               state_q <= ST_IDLE;
            end
         end
      end
   end

   assign launch_done = (state_q == ST_IDLE);

   assert_serial_ids_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (assign_valid && $past(assign_valid))
         |-> (assign_block_id == $past(assign_block_id) + BID_W'(1)));
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      launch_done |-> !assign_valid);
   assert_reject_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      launch_reject |-> launch_done);
endmodule

// File: tb/blk_dispatch_bench.sv
module blk_dispatch_bench;
   localparam int NMP = 2;
   localparam int WW  = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_valid = 1'b0;
   logic [15:0] launch_blocks = '0;
   logic [9:0]  launch_threads = '0;
   logic [7:0]  launch_regs = '0;
   logic        launch_reject;
   logic        done_valid = 1'b0;
   logic [0:0]  done_mp = '0;
   logic        assign_valid;
   logic [15:0] assign_block_id;
   logic [0:0]  assign_mp;
   logic        launch_done;
   logic [NMP*WW-1:0] mp_warps;

   int tests = 0;
   int fails = 0;
   int rec_n = 0;
   int rec_id [64];
   int rec_mp [64];

   always #2 clk = ~clk;

   blk_dispatch #(.NUM_MP(NMP)) u_blk_dispatch (
      .clk(clk), .rst_n(rst_n),
      .launch_valid(launch_valid), .launch_blocks(launch_blocks),
      .launch_threads(launch_threads), .launch_regs(launch_regs),
      .launch_reject(launch_reject),
      .done_valid(done_valid), .done_mp(done_mp),
      .assign_valid(assign_valid), .assign_block_id(assign_block_id),
      .assign_mp(assign_mp), .launch_done(launch_done), .mp_warps(mp_warps)
   );

   always @(posedge clk) begin
      #1;
      if (assign_valid && rec_n < 64) begin
         rec_id[rec_n] = int'(assign_block_id);
         rec_mp[rec_n] = int'(assign_mp);
         rec_n++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int warps_of(input int m);
      return int'(mp_warps[m*WW +: WW]);
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic launch(input int b, input int t, input int r);
      @(negedge clk);
      launch_valid   = 1'b1;
      launch_blocks  = 16'(b);
      launch_threads = 10'(t);
      launch_regs    = 8'(r);
      @(negedge clk);
      launch_valid   = 1'b0;
   endtask

   task automatic pulse_done(input int m);
      @(negedge clk);
      done_valid = 1'b1;
      done_mp    = 1'(m);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   task automatic drain(output int cnt);
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
         if (launch_done) break;
         if (warps_of(0) != 0) pulse_done(0);
         else if (warps_of(1) != 0) pulse_done(1);
         else wait_cyc(1);
         cnt++;
      end
   endtask

   task automatic check_pattern(input string req, input int n_exp, input int per_mp);
      check(rec_n == n_exp, req, rec_n, n_exp);
      for (int k = 0; k < n_exp && k < rec_n; k++) begin
         check(rec_id[k] == k, req, rec_id[k], k);
         check(rec_mp[k] == k / per_mp, req, rec_mp[k], k / per_mp);
      end
   endtask

   task automatic t_reset();
      check(launch_done == 1'b1, "R9", int'(launch_done), 1);
      check(assign_valid == 1'b0, "R6", int'(assign_valid), 0);
      check(launch_reject == 1'b0, "R5", int'(launch_reject), 0);
      check(mp_warps == '0, "R10", int'(mp_warps), 0);
   endtask

   // block-slot limit, ordering, lowest index, same-edge refill
   task automatic t_block_slots();
      int cnt;
      rec_n = 0;
      launch(20, 64, 2);
      check(launch_done == 1'b0, "R9", int'(launch_done), 0);
      check(assign_valid == 1'b0, "R6", int'(assign_valid), 0);
      @(posedge clk); #1;
      check(assign_valid && assign_block_id == 0, "R6", int'(assign_block_id), 0);
      wait_cyc(20);
      check_pattern("R2 R7", 16, 8);
      check(warps_of(0) == 16, "R10", warps_of(0), 16);
      check(warps_of(1) == 16, "R10", warps_of(1), 16);
      pulse_done(1);
      check(rec_n == 17, "R8", rec_n, 17);
      check(rec_id[16] == 16 && rec_mp[16] == 1, "R8", rec_mp[16], 1);
      check(warps_of(1) == 16, "R8", warps_of(1), 16);
      pulse_done(0);
      check(rec_id[17] == 17 && rec_mp[17] == 0, "R8", rec_mp[17], 0);
      drain(cnt);
      check(cnt == 18, "R9", cnt, 18);
      check(rec_n == 20, "R6", rec_n, 20);
      check(launch_done == 1'b1, "R9", int'(launch_done), 1);
   endtask

   task automatic t_thread_limit();
      int cnt;
      rec_n = 0;
      launch(8, 256, 1);
      wait_cyc(12);
      check_pattern("R3 R1", 6, 3);
      check(warps_of(0) == 24, "R10", warps_of(0), 24);
      drain(cnt);
      check(cnt == 8, "R9", cnt, 8);
   endtask

   task automatic t_reg_limit();
      int cnt;
      rec_n = 0;
      launch(10, 100, 16);
      wait_cyc(14);
      check_pattern("R4 R1", 8, 4);
      check(warps_of(1) == 16, "R10", warps_of(1), 16);
      drain(cnt);
      check(cnt == 10, "R9", cnt, 10);
      // demand exactly 8192 accepted, one block per multiprocessor
      rec_n = 0;
      launch(3, 512, 16);
      wait_cyc(6);
      check_pattern("R4", 2, 1);
      drain(cnt);
      check(cnt == 3, "R4", cnt, 3);
   endtask

   task automatic t_reject();
      int th [3] = '{513, 0, 512};
      int rg [3] = '{1, 1, 17};
      for (int k = 0; k < 3; k++) begin
         rec_n = 0;
         launch(4, th[k], rg[k]);
         check(launch_reject == 1'b1, "R5", int'(launch_reject), 1);
         check(launch_done == 1'b1, "R5", int'(launch_done), 1);
         wait_cyc(4);
         check(launch_reject == 1'b0, "R5", int'(launch_reject), 0);
         check(rec_n == 0, "R5", rec_n, 0);
      end
   endtask

   task automatic t_ignored();
      rec_n = 0;
      launch(0, 32, 1);
      check(launch_done == 1'b1, "R11", int'(launch_done), 1);
      wait_cyc(3);
      check(rec_n == 0, "R11", rec_n, 0);
      launch(1, 32, 1);
      wait_cyc(3);
      check(rec_n == 1 && rec_mp[0] == 0, "R11", rec_n, 1);
      launch(5, 32, 1);
      check(launch_reject == 1'b0, "R11", int'(launch_reject), 0);
      wait_cyc(4);
      check(rec_n == 1, "R11", rec_n, 1);
      pulse_done(1);
      check(launch_done == 1'b0, "R11", int'(launch_done), 0);
      check(warps_of(0) == 1, "R11", warps_of(0), 1);
      pulse_done(0);
      check(launch_done == 1'b1, "R9", int'(launch_done), 1);
      check(warps_of(0) == 0, "R8", warps_of(0), 0);
      wait_cyc(4);
      check(rec_n == 1, "R11", rec_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_block_slots();
      t_thread_limit();
      t_reg_limit();
      t_reject();
      t_ignored();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule